// File: doc/BRIEF.md
# Iterative Block Cipher Round Sequencer

This block is the control unit of an iterative AES-128 engine that computes one round at a time. It keeps the data path and the round-key path in step. It counts a fixed self-initialization period after reset. It then runs each 128-bit block through a fixed 44-cycle schedule: a load cycle, an initial key addition, ten rounds of four cycles each, a write-back cycle and a single presentation cycle, in which `out_valid` pulses.

The datapath follows a set of mutually exclusive strobes. For every round cycle it receives a round number and a phase number, together with a flag for the final round, in which the column-mix step is skipped. The sequencer also provides the index of the round key to apply. That index counts up for encryption and down for decryption, and the direction is latched when the block is loaded. Holding `run_en` low freezes progress for any number of cycles. A one-cycle `abort` discards the block in flight, and a new block can load in the very next cycle. While `run_en` stays high, blocks follow one another with no idle cycle between them.

Top module: `cipher_round_seq`

## Requirements
- R1: `init_done` is low after reset release until the 1024th rising clock edge. From that edge on it is high, and it stays high until the next reset.
- R2: `load_stb` (block cycle 1) asserts only in a cycle in which no block is in progress, `init_done`, `key_ready` and `run_en` are high, and `abort` is low.
- R3: With `run_en` held high, `out_valid` is high in cycle 44 of a block, 43 cycles after `load_stb`. It is high for that one cycle only.
- R4: If the start conditions of R2 hold in the cycle after `out_valid`, `load_stb` asserts in that cycle, so there is no gap between blocks.
- R5: While `run_en` is low, every strobe is low and the block position holds. When `run_en` returns high, the block resumes at the cycle where it stopped.
- R6: In a cycle with `abort` high, every strobe is low and the block in flight is discarded. A new `load_stb` may follow in the next cycle. `abort` does not clear `init_done`.
- R7: `dir_enc` (1 = encrypt, 0 = decrypt) is sampled only at `load_stb`, and `enc_mode` shows the sampled value. Changes of `dir_enc` later in the block have no effect.
- R8: `ark_stb` asserts in block cycle 2. `step_stb` asserts in cycles 3 to 42, with `round_idx` = 1 + (c-3)/4 and `phase_idx` = (c-3) mod 4. `last_round` is high only during round 10. `wb_stb` asserts in cycle 43. Outside `step_stb`, `round_idx` and `phase_idx` read 0.
- R9: `key_idx` is 0 for encryption and 10 for decryption during `ark_stb`. During round r it is r for encryption and 10-r for decryption. It is 0 when neither `ark_stb` nor `step_stb` is high.
- R10: While reset is asserted, every output is 0 except `enc_mode`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Advance enable; low pauses |
| abort | input | 1 | Synchronous discard of the block in flight |
| dir_enc | input | 1 | Direction, 1 encrypt, 0 decrypt |
| key_ready | input | 1 | Expanded key available |
| init_done | output | 1 | Self-initialization finished |
| load_stb | output | 1 | Take the input block (cycle 1) |
| ark_stb | output | 1 | Initial round-key addition (cycle 2) |
| step_stb | output | 1 | Round cycle (cycles 3 to 42) |
| wb_stb | output | 1 | Write-back cycle (cycle 43) |
| out_valid | output | 1 | Result valid, one cycle (cycle 44) |
| round_idx | output | 4 | Current round 1..10 during step_stb |
| phase_idx | output | 2 | Phase 0..3 inside a round |
| last_round | output | 1 | Final round, column mix skipped |
| key_idx | output | 4 | Round-key index to apply |
| enc_mode | output | 1 | Latched direction of the current block |

## Verification
All strobes and indices are combinational decodes of the registered block position and the current inputs. They are therefore due in the same cycle as the `run_en`/`abort`/`key_ready` values that qualify them, while position, direction and `init_done` change only at the next edge. The bench applies inputs on the falling edge, samples one time unit later, and updates its reference position model at the rising edge. With `run_en` held high, `out_valid` is due 43 cycles after `load_stb`, and each paused cycle adds one. The directed cases compare the observed cycle numbers of `load_stb`, `ark_stb` and `out_valid` against those counts.

// File: rtl/round_seq_pkg.sv
package round_seq_pkg;

  typedef struct packed {
    logic load;
    logic ark;
    logic step;
    logic wb;
    logic present;
  } seq_stb_t;

  // Round number (1-based) of a position inside the round window.
  function automatic int unsigned round_of(input int unsigned pos_i,
                                           input int unsigned phases);
    return (pos_i - 2) / phases + 1;
  endfunction

  // Phase inside the round for a position inside the round window.
  function automatic int unsigned phase_of(input int unsigned pos_i,
                                           input int unsigned phases);
    return (pos_i - 2) % phases;
  endfunction

  // Round-key index for a given round and direction.
  function automatic int unsigned key_of(input logic enc,
                                         input int unsigned rnd,
                                         input int unsigned rounds);
    return enc ? rnd : rounds - rnd;
  endfunction

  // Position that follows pos_i in a block of blk_len cycles.
  function automatic int unsigned next_pos(input int unsigned pos_i,
                                           input int unsigned blk_len);
    return (pos_i == blk_len - 1) ? 0 : pos_i + 1;
  endfunction

endpackage

// File: rtl/rs_init_timer.sv
module rs_init_timer #(
  parameter int unsigned INIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(INIT_CYCLES - 1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/rs_block_counter.sv
module rs_block_counter
  import round_seq_pkg::*;
#(
  parameter int unsigned BLK_LEN = 44,
  localparam int unsigned POS_W  = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             abort,
  input  logic             start_ok,
  output logic [POS_W-1:0] pos,
  output logic             fire
);
  // A cycle of the block is consumed when enabled and not aborted;
  // position 0 additionally needs the start conditions.
  assign fire = run_en && !abort && ((pos != '0) || start_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (abort) pos <= '0;
    else if (fire)  pos <= POS_W'(next_pos(32'(pos), BLK_LEN));
  end
endmodule

// File: rtl/rs_decode.sv
module rs_decode
  import round_seq_pkg::*;
#(
  parameter int unsigned ROUNDS = 10,
  parameter int unsigned PHASES = 4,
  parameter int unsigned POS_W  = 6,
  parameter int unsigned RND_W  = 4,
  parameter int unsigned PH_W   = 2
) (
  input  logic [POS_W-1:0] pos,
  input  logic             fire,
  input  logic             enc,
  output seq_stb_t         stb,
  output logic [RND_W-1:0] round_idx,
  output logic [PH_W-1:0]  phase_idx,
  output logic             last_round,
  output logic [RND_W-1:0] key_idx
);
  localparam int unsigned WB_POS  = 2 + ROUNDS * PHASES;
  localparam int unsigned OUT_POS = WB_POS + 1;

  int unsigned pos_i;
  int unsigned rnd_i;
  int unsigned ph_i;
  logic        in_rnd;

  always_comb begin
    pos_i  = 32'(pos);
    in_rnd = (pos_i >= 2) && (pos_i < WB_POS);
    rnd_i  = in_rnd ? round_of(pos_i, PHASES) : 0;
    ph_i   = in_rnd ? phase_of(pos_i, PHASES) : 0;

    stb.load    = fire && (pos_i == 0);
    stb.ark     = fire && (pos_i == 1);
    stb.step    = fire && in_rnd;
    stb.wb      = fire && (pos_i == WB_POS);
    stb.present = fire && (pos_i == OUT_POS);

    round_idx  = stb.step ? RND_W'(rnd_i) : '0;
    phase_idx  = stb.step ? PH_W'(ph_i) : '0;
    last_round = stb.step && (rnd_i == ROUNDS);

    if (stb.ark)       key_idx = RND_W'(key_of(enc, 0, ROUNDS));
    else if (stb.step) key_idx = RND_W'(key_of(enc, rnd_i, ROUNDS));
    else               key_idx = '0;
  end
endmodule

// File: rtl/cipher_round_seq.sv
module cipher_round_seq
  import round_seq_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 1024,
  parameter int unsigned ROUNDS      = 10,
  parameter int unsigned PHASES      = 4,
  localparam int unsigned BLK_LEN    = ROUNDS * PHASES + 4,
  localparam int unsigned POS_W      = $clog2(BLK_LEN),
  localparam int unsigned RND_W      = $clog2(ROUNDS + 1),
  localparam int unsigned PH_W       = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             abort,
  input  logic             dir_enc,
  input  logic             key_ready,
  output logic             init_done,
  output logic             load_stb,
  output logic             ark_stb,
  output logic             step_stb,
  output logic             wb_stb,
  output logic             out_valid,
  output logic [RND_W-1:0] round_idx,
  output logic [PH_W-1:0]  phase_idx,
  output logic             last_round,
  output logic [RND_W-1:0] key_idx,
  output logic             enc_mode
);
  logic             start_ok;
  logic [POS_W-1:0] pos;
  logic             fire;
  seq_stb_t         stb;

  rs_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (init_done)
  );

  assign start_ok = init_done && key_ready;

  rs_block_counter #(.BLK_LEN(BLK_LEN)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .abort    (abort),
    .start_ok (start_ok),
    .pos      (pos),
    .fire     (fire)
  );

  rs_decode #(
    .ROUNDS (ROUNDS),
    .PHASES (PHASES),
    .POS_W  (POS_W),
    .RND_W  (RND_W),
    .PH_W   (PH_W)
  ) u_dec (
    .pos        (pos),
    .fire       (fire),
    .enc        (enc_mode),
    .stb        (stb),
    .round_idx  (round_idx),
    .phase_idx  (phase_idx),
    .last_round (last_round),
    .key_idx    (key_idx)
  );

  // Direction is captured with the block and held for its whole life.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        enc_mode <= 1'b1;
    else if (stb.load) enc_mode <= dir_enc;
  end

  assign load_stb  = stb.load;
  assign ark_stb   = stb.ark;
  assign step_stb  = stb.step;
  assign wb_stb    = stb.wb;
  assign out_valid = stb.present;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned ROUNDS = 10,
  parameter int unsigned PHASES = 4,
  localparam int unsigned BLK_LEN = ROUNDS * PHASES + 4,
  localparam int unsigned RND_W   = $clog2(ROUNDS + 1),
  localparam int unsigned PH_W    = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int unsigned SL_W    = $clog2(BLK_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             abort,
  input logic             key_ready,
  input logic             init_done,
  input logic             load_stb,
  input logic             ark_stb,
  input logic             step_stb,
  input logic             wb_stb,
  input logic             out_valid,
  input logic [RND_W-1:0] round_idx,
  input logic [PH_W-1:0]  phase_idx,
  input logic             last_round,
  input logic [RND_W-1:0] key_idx,
  input logic             enc_mode
);
  logic            later_stb;
  logic [SL_W-1:0] since_load;

  assign later_stb = ark_stb || step_stb || wb_stb || out_valid;

  // Counts consumed block cycles since the last load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_load <= '0;
    else if (abort)                       since_load <= '0;
    else if (load_stb)                    since_load <= SL_W'(1);
    else if (later_stb && since_load != '0) since_load <= since_load + 1'b1;
  end

  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (init_done && key_ready && run_en && !abort));

  assert_valid_at_44_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_load == SL_W'(BLK_LEN - 1)));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid) && run_en && !abort && init_done && key_ready) |-> load_stb);

  assert_pause_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !(load_stb || later_stb));

  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !(load_stb || later_stb));

  assert_abort_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !later_stb);

  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_stb) |-> $stable(enc_mode));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_stb, ark_stb, step_stb, wb_stb, out_valid}));

  assert_last_round_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |-> (step_stb && round_idx == RND_W'(ROUNDS)));

  assert_round_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_stb) && step_stb && $past(phase_idx) != PH_W'(PHASES - 1))
      |-> (round_idx == $past(round_idx)));

  assert_enc_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && enc_mode) |-> (key_idx == round_idx));

  assert_dec_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb && !enc_mode) |-> (key_idx == RND_W'(ROUNDS) - round_idx));
endmodule

bind cipher_round_seq rs_checker #(.ROUNDS(ROUNDS), .PHASES(PHASES)) u_rs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .abort      (abort),
  .key_ready  (key_ready),
  .init_done  (init_done),
  .load_stb   (load_stb),
  .ark_stb    (ark_stb),
  .step_stb   (step_stb),
  .wb_stb     (wb_stb),
  .out_valid  (out_valid),
  .round_idx  (round_idx),
  .phase_idx  (phase_idx),
  .last_round (last_round),
  .key_idx    (key_idx),
  .enc_mode   (enc_mode)
);

// File: tb/test_cipher_round_seq.sv
module test_cipher_round_seq;
  localparam int INIT = 1024;
  localparam int NR   = 10;
  localparam int BLK  = 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, abort = 1'b0, dir_enc = 1'b1, key_ready = 1'b0;
  logic init_done, load_stb, ark_stb, step_stb, wb_stb, out_valid;
  logic [3:0] round_idx, key_idx;
  logic [1:0] phase_idx;
  logic last_round, enc_mode;

  always #4 clk = ~clk;

  cipher_round_seq i_cipher_round_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .abort(abort),
    .dir_enc(dir_enc), .key_ready(key_ready), .init_done(init_done),
    .load_stb(load_stb), .ark_stb(ark_stb), .step_stb(step_stb),
    .wb_stb(wb_stb), .out_valid(out_valid), .round_idx(round_idx),
    .phase_idx(phase_idx), .last_round(last_round), .key_idx(key_idx),
    .enc_mode(enc_mode)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int m_pos = 0, m_cnt = 0;
  bit m_rdy = 0, m_enc = 1;
  int g_load_cyc = -1, g_ov_cyc = -1, g_ark_key = -1, n_loads = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic string tag(input string ctx, input string dflt);
    return (ctx == "") ? dflt : ctx;
  endfunction

  // Called just after a falling edge; returns after the next falling edge.
  task automatic cycle(input bit en, input bit ab, input bit dr, input bit kr);
    bit f, e_ld, e_ark, e_st, e_wb, e_ov;
    int e_rnd, e_ph, e_key;
    string ctx;
    run_en = en; abort = ab; dir_enc = dr; key_ready = kr;
    #1;
    f     = en && !ab && (m_pos != 0 || (m_rdy && kr));
    e_ld  = f && m_pos == 0;
    e_ark = f && m_pos == 1;
    e_st  = f && m_pos >= 2 && m_pos <= 41;
    e_wb  = f && m_pos == 42;
    e_ov  = f && m_pos == 43;
    e_rnd = e_st ? 1 + (m_pos - 2) / 4 : 0;
    e_ph  = e_st ? (m_pos - 2) % 4 : 0;
    e_key = e_ark ? (m_enc ? 0 : NR) : (e_st ? (m_enc ? e_rnd : NR - e_rnd) : 0);
    ctx = ab ? "R6" : (!en ? "R5" : "");
    chk("R1", "init_done", 32'(init_done), 32'(m_rdy));
    chk(tag(ctx, "R2"), "load_stb", 32'(load_stb), 32'(e_ld));
    chk(tag(ctx, "R8"), "ark_stb", 32'(ark_stb), 32'(e_ark));
    chk(tag(ctx, "R8"), "step_stb", 32'(step_stb), 32'(e_st));
    chk(tag(ctx, "R8"), "wb_stb", 32'(wb_stb), 32'(e_wb));
    chk(tag(ctx, "R3"), "out_valid", 32'(out_valid), 32'(e_ov));
    chk("R8", "round_idx", 32'(round_idx), 32'(e_rnd));
    chk("R8", "phase_idx", 32'(phase_idx), 32'(e_ph));
    chk("R8", "last_round", 32'(last_round), 32'(e_st && e_rnd == NR));
    chk("R9", "key_idx", 32'(key_idx), 32'(e_key));
    chk("R7", "enc_mode", 32'(enc_mode), 32'(m_enc));
    if (load_stb)  begin g_load_cyc = cyc; n_loads++; end
    if (out_valid) g_ov_cyc = cyc;
    if (ark_stb)   g_ark_key = int'(key_idx);
    @(posedge clk);
    if (!m_rdy) begin m_cnt++; if (m_cnt == INIT) m_rdy = 1; end
    if (e_ld) m_enc = dr;
    if (ab) m_pos = 0;
    else if (f) m_pos = (m_pos == BLK - 1) ? 0 : m_pos + 1;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int L;
    void'($urandom(32'd20240517));
    // R10: outputs during reset
    run_en = 1; key_ready = 1; abort = 0; dir_enc = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R10", "reset outs", {25'd0, init_done, load_stb, ark_stb, step_stb,
          wb_stb, out_valid, last_round}, 32'd0);
      chk("R10", "reset idx", {20'd0, round_idx, phase_idx, key_idx, 1'b0, enc_mode}, 32'd1);
    end
    rst_n = 1;
    // R1/R2: self-init, no block may start before ready
    for (int i = 0; i < INIT; i++) cycle(1, 0, 1, 1);
    chk("R2", "loads during init", 32'(n_loads), 32'd0);
    chk("R1", "ready after 1024 edges", 32'(init_done), 32'd1);
    // R3/R4: continuous encryption
    L = cyc;
    for (int i = 0; i < BLK + 1; i++) cycle(1, 0, 1, 1);
    chk("R3", "out_valid cycle", 32'(g_ov_cyc), 32'(L + 43));
    chk("R4", "back-to-back load", 32'(g_load_cyc), 32'(L + 44));
    // R6/R7/R9: abort, decrypt block with direction flipped after load
    cycle(1, 1, 1, 1);
    L = cyc;
    cycle(1, 0, 0, 1);
    chk("R6", "load right after abort", 32'(g_load_cyc), 32'(L));
    for (int i = 0; i < BLK - 1; i++) cycle(1, 0, 1, 1);
    chk("R7", "dec key at ark", 32'(g_ark_key), 32'(NR));
    chk("R7", "dec out_valid", 32'(g_ov_cyc), 32'(L + 43));
    // R5: pause of 20 cycles mid-block
    cycle(1, 1, 1, 1);
    g_ov_cyc = -1;
    L = cyc;
    for (int i = 0; i < 10; i++) cycle(1, 0, 1, 1);
    for (int i = 0; i < 20; i++) cycle(0, 0, 0, 1);
    for (int i = 0; i < 34; i++) cycle(1, 0, 0, 1);
    chk("R5", "paused out_valid", 32'(g_ov_cyc), 32'(L + 63));
    chk("R7", "enc kept through pause", 32'(enc_mode), 32'd1);
    // R6: abort mid-block then immediate restart
    cycle(1, 1, 1, 1);
    for (int i = 0; i < 12; i++) cycle(1, 0, 1, 1);
    cycle(1, 1, 0, 1);
    L = cyc;
    cycle(1, 0, 0, 1);
    chk("R6", "restart after mid abort", 32'(g_load_cyc), 32'(L));
    chk("R6", "init_done kept", 32'(init_done), 32'd1);
    // R2: key not ready at block boundary
    cycle(1, 1, 1, 1);
    n_loads = 0;
    for (int i = 0; i < 5; i++) cycle(1, 0, 1, 0);
    chk("R2", "no load without key", 32'(n_loads), 32'd0);
    // random mix
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 10) < 8, ($urandom % 60) == 0, 1'($urandom % 2),
            ($urandom % 20) != 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule